// File: doc/BRIEF.md
# Daisy-Chainable Serial Latched Output Register

This block is the digital front end of a sixteen-channel sink-output controller. A host drives four pins: a serial data pin, a serial clock, a load-enable and a blanking input. Each rising serial-clock edge moves the 16-bit shift register up by one place and takes the data pin into the lowest bit. The word therefore arrives most significant bit first. The top stage is presented on a serial output pin, so several of these blocks can be chained with one word per device.

A holding register drives the channel state vector. It copies the shift register continuously while load-enable is high and freezes on load-enable's falling edge. A two-state machine controls it: `LATCH_HOLD` keeps the stored word, and `LATCH_FOLLOW` copies the shift register on every system cycle. The transition `HOLD->FOLLOW` is taken when the synchronized load-enable is high. The transition `FOLLOW->HOLD` is taken when it goes low. On that last cycle the register makes one final copy, which is the capture.

The blanking input only masks the drive-enable vector, which models the high-impedance condition. It never touches the shift register or the holding register. All four pins are sampled by the faster system clock through multi-stage synchronizers. Serial-clock edges are found by comparing each synchronized sample with the one taken one cycle earlier.

Top module: `serial_latch_driver`

## Requirements
- R1: While `rst_n` is low at a system clock edge, the shift register and the holding register clear to zero. After that edge `chan_state`, `chan_drive_en` and `ser_dout` read 0, and the drive-enable stays 0 until `blank` is sampled low after release.
- R2: Each rising edge of `ser_clk` shifts the register up one bit and takes `ser_din` into bit 0. Sixteen edges therefore place the first bit sent in bit 15 (channel 15) and the last bit sent in bit 0 (channel 0).
- R3: `ser_dout` shows bit 15 of the shift register and changes only after a rising `ser_clk` edge. A bit presented on `ser_din` reaches `ser_dout` after the 16th rising edge.
- R4: While `load_en` is high, `chan_state` follows the shift register, including shifts that happen during that time.
- R5: On the falling edge of `load_en`, `chan_state` takes the shift register value. While `load_en` stays low, it keeps that value whatever happens on `ser_clk` and `ser_din`.
- R6: While `blank` is high, `chan_drive_en` is all zeros and `chan_state` is not changed by the blanking.
- R7: While `blank` is low, `chan_drive_en[i]` equals `chan_state[i]`, where a 1 means channel i is on.
- R8: Shifting and loading behave the same whether `blank` is high or low. A word loaded while blanked appears on `chan_drive_en` once `blank` goes low.
- R9: A falling edge of `ser_clk` does not shift the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_din | input | 1 | Serial data, sampled on rising `ser_clk` |
| ser_clk | input | 1 | Serial shift clock (asynchronous pin) |
| load_en | input | 1 | Holding register transparent while high, captures on fall |
| blank | input | 1 | High forces all drive-enables off |
| ser_dout | output | 1 | Top shift stage, for chaining |
| chan_state | output | 16 | Holding register contents, 1 = channel on |
| chan_drive_en | output | 16 | Per-channel drive enable, 0 = high impedance |

## Verification
The assertions assume that every pin stays at one level for longer than the synchronizer depth plus one system cycle. They also assume that `ser_din` is stable on the synchronized sample where a rising `ser_clk` is detected, so the register moves by exactly one position per serial edge. The stimulus keeps within this: each pin changes on its own, and five system cycles of settling follow each change before the next pin moves or any output is compared. No two pins ever change in the same system cycle.

// File: rtl/sld_pkg.sv
package sld_pkg;

    typedef enum logic [0:0] {
        LATCH_HOLD   = 1'b0,
        LATCH_FOLLOW = 1'b1
    } latch_state_e;

    localparam int unsigned SLD_MIN_SYNC = 2;

endpackage

// File: rtl/sld_pin_sync.sv
module sld_pin_sync #(
    parameter int unsigned NUM_PINS  = 4,
    parameter int unsigned STAGES    = 2,
    parameter logic [NUM_PINS-1:0] RESET_VAL = '0
) (
    input  logic                sys_clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_sync
);

    initial begin
        if (STAGES < sld_pkg::SLD_MIN_SYNC) begin
            $error("sld_pin_sync: STAGES must be at least 2");
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [STAGES-1:0] chain;

        always_ff @(posedge sys_clk) begin
            if (!rst_n) begin
                chain <= {STAGES{RESET_VAL[p]}};
            end else begin
                chain <= {chain[STAGES-2:0], pin_in[p]};
            end
        end

        assign pin_sync[p] = chain[STAGES-1];
    end

endmodule

// File: rtl/sld_shift_chain.sv
module sld_shift_chain #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             sys_clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic [WIDTH-1:0] word,
    output logic             ser_out
);

    localparam int unsigned TOP = WIDTH - 1;

    always_ff @(posedge sys_clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[TOP-1:0], ser_in};
        end
    end

    assign ser_out = word[TOP];

endmodule

// File: rtl/sld_latch_ctrl.sv
module sld_latch_ctrl
    import sld_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             sys_clk,
    input  logic             rst_n,
    input  logic             load_lvl,
    input  logic [WIDTH-1:0] shift_word,
    output latch_state_e     state,
    output logic [WIDTH-1:0] held_word
);

    latch_state_e state_nxt;

    // state register
    always_ff @(posedge sys_clk) begin
        if (!rst_n) begin
            state <= LATCH_HOLD;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            LATCH_HOLD:   if (load_lvl)  state_nxt = LATCH_FOLLOW;
            LATCH_FOLLOW: if (!load_lvl) state_nxt = LATCH_HOLD;
            default:      state_nxt = LATCH_HOLD;
        endcase
    end

    // outputs: copy while following; the last copy before HOLD is the capture
    always_ff @(posedge sys_clk) begin
        if (!rst_n) begin
            held_word <= '0;
        end else begin
            unique case (state)
                LATCH_FOLLOW: held_word <= shift_word;
                LATCH_HOLD:   held_word <= held_word;
                default:      held_word <= held_word;
            endcase
        end
    end

endmodule

// File: rtl/sld_blank_gate.sv
module sld_blank_gate #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             blank_lvl,
    input  logic [WIDTH-1:0] held_word,
    output logic [WIDTH-1:0] drive_en
);

    for (genvar c = 0; c < WIDTH; c++) begin : g_chan
        assign drive_en[c] = held_word[c] & ~blank_lvl;
    end

endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver
    import sld_pkg::*;
#(
    parameter int unsigned WIDTH       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             sys_clk,
    input  logic             rst_n,
    input  logic             ser_din,
    input  logic             ser_clk,
    input  logic             load_en,
    input  logic             blank,
    output logic             ser_dout,
    output logic [WIDTH-1:0] chan_state,
    output logic [WIDTH-1:0] chan_drive_en
);

    localparam int unsigned NPIN     = 4;
    localparam int unsigned PIN_DIN  = 0;
    localparam int unsigned PIN_SCLK = 1;
    localparam int unsigned PIN_LOAD = 2;
    localparam int unsigned PIN_BLNK = 3;
    // blanking pin resets high so outputs stay disabled during reset
    localparam logic [NPIN-1:0] PIN_RST = 4'b1000;

    logic [NPIN-1:0]  pins_raw;
    logic [NPIN-1:0]  pins_q;
    logic             din_q;
    logic             sclk_q;
    logic             sclk_prev;
    logic             load_q;
    logic             blank_q;
    logic             sclk_rise;
    logic [WIDTH-1:0] shift_word;
    logic [WIDTH-1:0] held_word;
    latch_state_e     lstate;

    assign pins_raw[PIN_DIN]  = ser_din;
    assign pins_raw[PIN_SCLK] = ser_clk;
    assign pins_raw[PIN_LOAD] = load_en;
    assign pins_raw[PIN_BLNK] = blank;

    sld_pin_sync #(
        .NUM_PINS  (NPIN),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (PIN_RST)
    ) u_sync (
        .sys_clk  (sys_clk),
        .rst_n    (rst_n),
        .pin_in   (pins_raw),
        .pin_sync (pins_q)
    );

    assign din_q   = pins_q[PIN_DIN];
    assign sclk_q  = pins_q[PIN_SCLK];
    assign load_q  = pins_q[PIN_LOAD];
    assign blank_q = pins_q[PIN_BLNK];

    always_ff @(posedge sys_clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= sclk_q;
        end
    end

    assign sclk_rise = sclk_q & ~sclk_prev;

    sld_shift_chain #(
        .WIDTH (WIDTH)
    ) u_shift (
        .sys_clk  (sys_clk),
        .rst_n    (rst_n),
        .shift_en (sclk_rise),
        .ser_in   (din_q),
        .word     (shift_word),
        .ser_out  (ser_dout)
    );

    sld_latch_ctrl #(
        .WIDTH (WIDTH)
    ) u_latch (
        .sys_clk    (sys_clk),
        .rst_n      (rst_n),
        .load_lvl   (load_q),
        .shift_word (shift_word),
        .state      (lstate),
        .held_word  (held_word)
    );

    sld_blank_gate #(
        .WIDTH (WIDTH)
    ) u_gate (
        .blank_lvl (blank_q),
        .held_word (held_word),
        .drive_en  (chan_drive_en)
    );

    assign chan_state = held_word;

endmodule

// File: rtl/sld_checker.sv
module sld_checker
    import sld_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input logic             sys_clk,
    input logic             rst_n,
    input logic             sclk_rise,
    input logic             din_q,
    input logic             blank_q,
    input latch_state_e     lstate,
    input logic [WIDTH-1:0] shift_word,
    input logic [WIDTH-1:0] chan_state,
    input logic [WIDTH-1:0] chan_drive_en,
    input logic             ser_dout
);

    logic in_rst_q;

    always_ff @(posedge sys_clk) begin
        in_rst_q <= !rst_n;
    end

    // R1
    always @(negedge sys_clk) begin
        if (in_rst_q) begin
            reset_clear_chk: assert (chan_state == '0 && chan_drive_en == '0 && ser_dout == 1'b0)
                else $error("reset did not clear outputs");
        end
    end

    // R2
    shift_step_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        sclk_rise |=> shift_word == {$past(shift_word[WIDTH-2:0]), $past(din_q)});

    // R9
    no_shift_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(shift_word));

    // R3
    dout_steady_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(ser_dout));

    // R4
    follow_copy_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        lstate == LATCH_FOLLOW |=> chan_state == $past(shift_word));

    // R5
    hold_stable_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (lstate == LATCH_HOLD && $past(lstate) == LATCH_HOLD && $past(rst_n)) |-> $stable(chan_state));

    // R6
    blank_off_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        blank_q |-> chan_drive_en == '0);

    // R7
    unblank_follow_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !blank_q |-> chan_drive_en == chan_state);

endmodule

bind serial_latch_driver sld_checker #(.WIDTH(WIDTH)) u_chk (
    .sys_clk       (sys_clk),
    .rst_n         (rst_n),
    .sclk_rise     (sclk_rise),
    .din_q         (din_q),
    .blank_q       (blank_q),
    .lstate        (lstate),
    .shift_word    (shift_word),
    .chan_state    (chan_state),
    .chan_drive_en (chan_drive_en),
    .ser_dout      (ser_dout)
);

// File: tb/serial_latch_driver_bench.sv
`timescale 1ns/1ps
module serial_latch_driver_bench;

    localparam int W = 16;

    typedef struct {
        string        tag;
        logic [W-1:0] st;
        logic [W-1:0] drv;
        logic         dout;
    } exp_t;

    logic         sys_clk = 1'b0;
    logic         rst_n   = 1'b0;
    logic         ser_din = 1'b0;
    logic         ser_clk = 1'b0;
    logic         load_en = 1'b0;
    logic         blank   = 1'b0;
    logic         ser_dout;
    logic [W-1:0] chan_state;
    logic [W-1:0] chan_drive_en;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    exp_t sb_q[$];
    event push_ev;

    logic [W-1:0] m_sr  = '0;
    logic [W-1:0] m_lat = '0;
    bit           m_le  = 0;
    bit           m_blk = 0;

    always #10 sys_clk = ~sys_clk;

    serial_latch_driver u_serial_latch_driver (
        .sys_clk       (sys_clk),
        .rst_n         (rst_n),
        .ser_din       (ser_din),
        .ser_clk       (ser_clk),
        .load_en       (load_en),
        .blank         (blank),
        .ser_dout      (ser_dout),
        .chan_state    (chan_state),
        .chan_drive_en (chan_drive_en)
    );

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            @(push_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (chan_state !== e.st || chan_drive_en !== e.drv || ser_dout !== e.dout) begin
                    errors++;
                    $display("FAIL %s: state=%h drive=%h dout=%b expected state=%h drive=%h dout=%b",
                             e.tag, chan_state, chan_drive_en, ser_dout, e.st, e.drv, e.dout);
                end
            end
        end
    end

    task automatic settle();
        repeat (5) @(posedge sys_clk);
        @(negedge sys_clk);
    endtask

    task automatic expect_now(input string tag);
        exp_t e;
        e.tag  = tag;
        e.st   = m_lat;
        e.drv  = m_blk ? '0 : m_lat;
        e.dout = m_sr[W-1];
        sb_q.push_back(e);
        ->push_ev;
        #1;
    endtask

    task automatic shift_bit(input logic b);
        ser_din = b;
        settle();
        ser_clk = 1'b1;
        settle();
        m_sr = {m_sr[W-2:0], b};
        if (m_le) m_lat = m_sr;
        ser_clk = 1'b0;
        settle();
    endtask

    task automatic shift_word(input logic [W-1:0] w);
        for (int i = W - 1; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic set_load(input bit v);
        load_en = v;
        settle();
        m_le = v;
        if (v) m_lat = m_sr;
    endtask

    task automatic set_blank(input bit v);
        blank = v;
        settle();
        m_blk = v;
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge sys_clk);
                if (!finished) begin
                    errors++;
                    checks++;
                    $display("FAIL watchdog: run hung, actual=timeout expected=done");
                    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                    $finish;
                end
            end
        join_none

        repeat (4) @(posedge sys_clk);
        @(negedge sys_clk);
        expect_now("R1 reset clears outputs");
        rst_n = 1'b1;
        settle();
        expect_now("R1 after release");

        // R2 R3 R5: shift with load low, holding register keeps zero
        shift_word(16'hA5C3);
        expect_now("R5 load low keeps old word, R3 dout=bit15");

        // R4 R5 R7: load pulse
        set_load(1);
        expect_now("R4 transparent while load high, R7 drive follows");
        // R4: shift while load high, state follows
        shift_bit(1'b0);
        expect_now("R4 shift during load high");
        set_load(0);
        expect_now("R5 captured on load fall, R2 order");
        shift_word(16'h1234);
        expect_now("R5 hold while clocking, R9 no shift on fall");

        // R6 R8
        set_blank(1);
        expect_now("R6 blank forces drive off, state unchanged");
        set_load(1);
        set_load(0);
        expect_now("R8 load while blanked");
        set_blank(0);
        expect_now("R7 R8 drive shows word loaded while blanked");

        // R3: single one travels to dout after 16 edges
        shift_bit(1'b1);
        for (int k = 1; k < W; k++) begin
            expect_now("R3 dout latency");
            shift_bit(1'b0);
        end
        expect_now("R3 dout after 16th edge");
        shift_bit(1'b0);
        expect_now("R3 dout after 17th edge");

        // R9: a lone falling edge of ser_clk changes nothing
        ser_clk = 1'b1;
        settle();
        m_sr = {m_sr[W-2:0], ser_din};
        expect_now("R9 rise shifts");
        ser_clk = 1'b0;
        settle();
        expect_now("R9 fall does not shift");

        // R2: distinct word, full check of channel order
        shift_word(16'h8001);
        set_load(1);
        set_load(0);
        expect_now("R2 first bit in channel 15, last in channel 0");

        // R1: reset mid-run
        rst_n = 1'b0;
        settle();
        m_sr = '0; m_lat = '0; m_le = 0;
        expect_now("R1 reset mid-run");
        rst_n = 1'b1;
        settle();
        expect_now("R1 stays clear after release");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule